// File: doc/BRIEF.md
# Virtual Load/Store Port Allocator

This block lets instruction decode hand out load/store port tags without waiting for a physical queue entry to become free. Decode draws tags from a virtual pool that is larger than the physical load/store queue. It keeps decoding while every physical entry is occupied, and it stalls only when the virtual pool itself cannot cover a request. A vector memory operation that needs several entries asks for up to four tags at once. It receives either all of them or none.

Granted tags wait in an age-ordered binding stage on the memory side. That stage pairs the oldest waiting tag with a free physical entry, at most one pairing per cycle. A paired operation is then presented at the dispatch port. When the memory pipeline completes an operation, it names the physical entry it used. That release travels through a fixed-latency notification pipeline. At the end of that pipeline the physical entry and its virtual tag both return to service. A flush returns every tag that has not yet been paired. Paired operations are left to finish and release normally.

Top module: `vport_alloc`

## Requirements
- R1: After reset the pool holds all 16 tags, no physical entry is occupied and `disp_valid` is low.
- R2: A request is granted, in the same cycle, exactly when `dec_req_valid` is high, `flush` is low, the count is between 1 and 4 and the count does not exceed the free tags. Field k of `dec_tags` (bits 4k+3..4k) then carries the k-th lowest-numbered free tag, in ascending order. A refused request leaves the pool unchanged.
- R3: Decode keeps getting grants while all 8 physical entries are occupied, as long as free tags remain.
- R4: A request is refused when the pool holds fewer free tags than the count asks for.
- R5: At most one waiting tag is paired per cycle, the oldest first, with the lowest-numbered free physical entry. A tag granted in cycle t can be paired in cycle t+1 at the earliest.
- R6: An operation is presented at the dispatch port only after it is paired, so no earlier than two cycles after its grant. Operations appear in pairing order, and the presented operation holds steady while `disp_ready` is low.
- R7: No two live operations hold the same physical entry, and no new pairing is made while all physical entries are occupied.
- R8: A release presented in cycle t frees the physical entry and its tag at the end of cycle t+3. The tag can therefore be granted again in cycle t+4 but not before, and the entry can be paired again in cycle t+4.
- R9: A flush returns all unpaired tags so that they can be granted in the next cycle. It blocks grants and pairing in its own cycle and leaves paired operations at the dispatch port untouched.
- R10: The number of free tags, plus the tags waiting for pairing, plus the occupied physical entries, always equals 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_req_valid | input | 1 | Decode asks for tags this cycle |
| dec_req_cnt | input | 3 | Number of tags requested (1 to 4) |
| dec_grant | output | 1 | Request granted this cycle |
| dec_tags | output | 16 | Granted tags, 4 bits per field, lowest field first |
| flush | input | 1 | Drop all unpaired tags |
| disp_valid | output | 1 | A paired operation is offered to the memory pipeline |
| disp_ready | input | 1 | Memory pipeline accepts the offered operation |
| disp_vtag | output | 4 | Virtual tag of the offered operation |
| disp_pidx | output | 3 | Physical entry bound to the offered operation |
| rel_valid | input | 1 | Completion releases a physical entry |
| rel_pidx | input | 3 | Physical entry being released |

## Verification
The hardest situation to reach is a release that lands while the pool is empty, every physical entry is busy and paired-waiting tags are queued behind it. In that state the single returning entry decides two things: the exact cycle in which decode can regain a tag, and which waiting tag gets the entry. To build that state, the stimulus grants eight tags, drains all eight dispatches and grants the remaining eight. It then issues one release and repeats a one-tag request every cycle. This pins the first grant to the fourth cycle after the release and the new dispatch to the fifth.

// File: rtl/vport_pkg.sv
// Package: default sizing shared by the allocator and its checker.
// Assumes: physical and virtual counts are powers of two.
package vport_pkg;
    localparam int DEF_PHYS      = 8;
    localparam int DEF_VIRT      = 16;
    localparam int DEF_MAX_REQ   = 4;
    localparam int DEF_REL_DELAY = 3;
endpackage

// File: rtl/vport_tag_pool.sv
// Module: virtual tag pool. It holds one free bit per tag and offers the
// MAX_REQ lowest free tags each cycle. It removes the first alloc_n of them
// when alloc_en is high, and takes returned tags back from ret_mask.
// Assumes: ret_mask never names a tag that is currently free.
module vport_tag_pool #(
    parameter int NUM_VIRT = 16,
    parameter int MAX_REQ  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  alloc_en,
    input  logic [$clog2(MAX_REQ+1)-1:0]          alloc_n,
    input  logic [NUM_VIRT-1:0]                   ret_mask,
    output logic [$clog2(NUM_VIRT+1)-1:0]         free_cnt,
    output logic [MAX_REQ*$clog2(NUM_VIRT)-1:0]   pick_tags,
    output logic [NUM_VIRT-1:0]                   alloc_mask
);
    localparam int TW = $clog2(NUM_VIRT);
    localparam int CW = $clog2(NUM_VIRT+1);

    logic [NUM_VIRT-1:0] free_q;
    logic [NUM_VIRT-1:0] scan;
    logic                hit;

    // Pick the MAX_REQ lowest free tags; mark the first alloc_n of them for removal
    always_comb begin
        scan       = free_q;
        alloc_mask = '0;
        pick_tags  = '0;
        hit        = 1'b0;
        for (int k = 0; k < MAX_REQ; k++) begin
            hit = 1'b0;
            for (int i = 0; i < NUM_VIRT; i++) begin
                if (!hit && scan[i]) begin
                    hit                   = 1'b1;
                    scan[i]               = 1'b0;
                    pick_tags[k*TW +: TW] = TW'(i);
                    if (k < int'(alloc_n)) begin
                        alloc_mask[i] = 1'b1;
                    end
                end
            end
        end
    end

    // Count of free tags offered to decode
    assign free_cnt = CW'($countones(free_q));

    // Free bit update: remove granted tags, add returned tags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
        end else begin
            free_q <= (free_q & ~(alloc_en ? alloc_mask : {NUM_VIRT{1'b0}})) | ret_mask;
        end
    end
endmodule

// File: rtl/vport_fifo.sv
// Module: age-ordered queue that takes up to MAX_PUSH entries per cycle
// (slot 0 oldest) and pops one. clear empties it in one cycle.
// Assumes: DEPTH is a power of two and the user never overfills it or
// pops it while empty.
module vport_fifo #(
    parameter int DEPTH    = 16,
    parameter int W        = 4,
    parameter int MAX_PUSH = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic [$clog2(MAX_PUSH+1)-1:0]        push_n,
    input  logic [MAX_PUSH*W-1:0]                push_data,
    input  logic                                 pop,
    output logic [W-1:0]                         head,
    output logic                                 empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   cnt;

    // Storage write: place each pushed slot behind the current tail
    always_ff @(posedge clk) begin
        for (int k = 0; k < MAX_PUSH; k++) begin
            if (k < int'(push_n)) begin
                mem[wr_ptr + AW'(k)] <= push_data[k*W +: W];
            end
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop);
            cnt    <= cnt + (AW+1)'(push_n) - (AW+1)'(pop);
        end
    end

    // Oldest entry and empty flag
    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
endmodule

// File: rtl/vport_rel_pipe.sv
// Module: fixed-latency release notification line. A release entering in
// cycle t leaves in cycle t+DEPTH.
// Assumes: DEPTH >= 1.
module vport_rel_pipe #(
    parameter int DEPTH = 3,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_idx,
    output logic         out_valid,
    output logic [W-1:0] out_idx
);
    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    // Valid bits shift one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_valid;
            for (int s = 1; s < DEPTH; s++) begin
                v_q[s] <= v_q[s-1];
            end
        end
    end

    // Entry index travels beside its valid bit
    always_ff @(posedge clk) begin
        d_q[0] <= in_idx;
        for (int s = 1; s < DEPTH; s++) begin
            d_q[s] <= d_q[s-1];
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_idx   = d_q[DEPTH-1];
endmodule

// File: rtl/vport_phys_map.sv
// Module: physical entry table. It tracks one busy bit and the owning tag
// per entry, offers the lowest free entry for pairing, and reports the
// owner of an entry being released.
// Assumes: a release never names a free entry.
module vport_phys_map #(
    parameter int NUM_PHYS = 8,
    parameter int TW       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bind_en,
    input  logic [TW-1:0]                bind_tag,
    input  logic                         rel_en,
    input  logic [$clog2(NUM_PHYS)-1:0]  rel_idx,
    output logic                         any_free,
    output logic [$clog2(NUM_PHYS)-1:0]  pick_idx,
    output logic [TW-1:0]                rel_owner,
    output logic [NUM_PHYS-1:0]          busy,
    output logic [NUM_PHYS*TW-1:0]       owner_flat
);
    localparam int PW = $clog2(NUM_PHYS);

    logic [NUM_PHYS-1:0] busy_q;
    logic [TW-1:0]       owner_q [NUM_PHYS];

    // Lowest-numbered free entry
    always_comb begin
        pick_idx = '0;
        any_free = 1'b0;
        for (int i = NUM_PHYS-1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                pick_idx = PW'(i);
                any_free = 1'b1;
            end
        end
    end

    // Busy and owner update on pairing and on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < NUM_PHYS; i++) begin
                owner_q[i] <= '0;
            end
        end else begin
            if (bind_en) begin
                busy_q[pick_idx]  <= 1'b1;
                owner_q[pick_idx] <= bind_tag;
            end
            if (rel_en) begin
                busy_q[rel_idx] <= 1'b0;
            end
        end
    end

    assign rel_owner = owner_q[rel_idx];
    assign busy      = busy_q;

    // Flattened owner view
    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_own
        assign owner_flat[g*TW +: TW] = owner_q[g];
    end
endmodule

// File: rtl/vport_alloc.sv
// Module: top of the virtual load/store port allocator. Decode takes tags
// from an oversubscribed pool. A pairing stage binds the oldest waiting tag
// to a free physical entry, one per cycle. Paired operations queue for
// dispatch. Delayed releases return both the entry and its tag.
// Assumes: releases only name dispatched, unreleased entries.
module vport_alloc #(
    parameter int NUM_PHYS  = vport_pkg::DEF_PHYS,
    parameter int NUM_VIRT  = vport_pkg::DEF_VIRT,
    parameter int MAX_REQ   = vport_pkg::DEF_MAX_REQ,
    parameter int REL_DELAY = vport_pkg::DEF_REL_DELAY
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  dec_req_valid,
    input  logic [$clog2(MAX_REQ+1)-1:0]          dec_req_cnt,
    output logic                                  dec_grant,
    output logic [MAX_REQ*$clog2(NUM_VIRT)-1:0]   dec_tags,
    input  logic                                  flush,
    output logic                                  disp_valid,
    input  logic                                  disp_ready,
    output logic [$clog2(NUM_VIRT)-1:0]           disp_vtag,
    output logic [$clog2(NUM_PHYS)-1:0]           disp_pidx,
    input  logic                                  rel_valid,
    input  logic [$clog2(NUM_PHYS)-1:0]           rel_pidx
);
    localparam int TW = $clog2(NUM_VIRT);
    localparam int PW = $clog2(NUM_PHYS);
    localparam int NW = $clog2(MAX_REQ+1);
    localparam int CW = $clog2(NUM_VIRT+1);

    logic [CW-1:0]           free_cnt;
    logic [NUM_VIRT-1:0]     alloc_mask;
    logic [NUM_VIRT-1:0]     ret_mask;
    logic [NUM_VIRT-1:0]     unbound_q;
    logic [NW-1:0]           bq_push_n;
    logic [TW-1:0]           bq_head;
    logic                    bq_empty;
    logic                    bind_fire;
    logic                    any_free;
    logic [PW-1:0]           pick_idx;
    logic [TW-1:0]           rel_owner;
    logic [NUM_PHYS-1:0]     phys_busy;
    logic [NUM_PHYS*TW-1:0]  phys_owner_flat;
    logic                    rp_valid;
    logic [PW-1:0]           rp_idx;
    logic                    iq_empty;
    logic [TW+PW-1:0]        iq_head;

    // All-or-nothing grant against the free tag count
    assign dec_grant = dec_req_valid && !flush && (dec_req_cnt != '0)
                       && (int'(dec_req_cnt) <= MAX_REQ)
                       && (int'(dec_req_cnt) <= int'(free_cnt));

    // Tags go back on flush (unpaired ones) or at the end of the release line
    assign ret_mask = (flush ? unbound_q : {NUM_VIRT{1'b0}})
                    | (rp_valid ? (NUM_VIRT'(1) << rel_owner) : {NUM_VIRT{1'b0}});

    vport_tag_pool #(.NUM_VIRT(NUM_VIRT), .MAX_REQ(MAX_REQ)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (dec_grant),
        .alloc_n    (dec_req_cnt),
        .ret_mask   (ret_mask),
        .free_cnt   (free_cnt),
        .pick_tags  (dec_tags),
        .alloc_mask (alloc_mask)
    );

    // Granted tags enter the pairing queue in ascending, oldest-first order
    assign bq_push_n = dec_grant ? dec_req_cnt : '0;
    assign bind_fire = !bq_empty && any_free && !flush;

    vport_fifo #(.DEPTH(NUM_VIRT), .W(TW), .MAX_PUSH(MAX_REQ)) u_bindq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push_n    (bq_push_n),
        .push_data (dec_tags),
        .pop       (bind_fire),
        .head      (bq_head),
        .empty     (bq_empty)
    );

    // Track which tags are granted but not yet paired
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            unbound_q <= '0;
        end else begin
            unbound_q <= (unbound_q | (dec_grant ? alloc_mask : {NUM_VIRT{1'b0}}))
                       & ~(bind_fire ? (NUM_VIRT'(1) << bq_head) : {NUM_VIRT{1'b0}});
        end
    end

    vport_rel_pipe #(.DEPTH(REL_DELAY), .W(PW)) u_relpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rel_valid),
        .in_idx    (rel_pidx),
        .out_valid (rp_valid),
        .out_idx   (rp_idx)
    );

    vport_phys_map #(.NUM_PHYS(NUM_PHYS), .TW(TW)) u_pmap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bind_en    (bind_fire),
        .bind_tag   (bq_head),
        .rel_en     (rp_valid),
        .rel_idx    (rp_idx),
        .any_free   (any_free),
        .pick_idx   (pick_idx),
        .rel_owner  (rel_owner),
        .busy       (phys_busy),
        .owner_flat (phys_owner_flat)
    );

    // Paired operations wait here for the memory pipeline
    vport_fifo #(.DEPTH(NUM_PHYS), .W(TW+PW), .MAX_PUSH(1)) u_issueq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (1'b0),
        .push_n    (bind_fire),
        .push_data ({bq_head, pick_idx}),
        .pop       (disp_valid && disp_ready),
        .head      (iq_head),
        .empty     (iq_empty)
    );

    assign disp_valid = !iq_empty;
    assign disp_vtag  = iq_head[TW+PW-1:PW];
    assign disp_pidx  = iq_head[PW-1:0];
endmodule

// File: rtl/vport_alloc_chk.sv
// Module: property checker for vport_alloc, attached by bind.
// Assumes: it observes the pool count, the unpaired set and the physical table.
module vport_alloc_chk #(
    parameter int NUM_PHYS = 8,
    parameter int NUM_VIRT = 16
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   flush,
    input logic                                   disp_valid,
    input logic                                   disp_ready,
    input logic [$clog2(NUM_VIRT)-1:0]            disp_vtag,
    input logic [$clog2(NUM_PHYS)-1:0]            disp_pidx,
    input logic [$clog2(NUM_VIRT+1)-1:0]          free_cnt,
    input logic [NUM_VIRT-1:0]                    unbound_vec,
    input logic [NUM_PHYS-1:0]                    busy_vec,
    input logic [NUM_PHYS*$clog2(NUM_VIRT)-1:0]   owner_flat
);
    localparam int TW = $clog2(NUM_VIRT);

    AST_TAG_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) + $countones(unbound_vec) + $countones(busy_vec)) == NUM_VIRT); // R10

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (unbound_vec == '0)); // R9

    AST_DISP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> busy_vec[disp_pidx]); // R6

    AST_ONE_BIND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(busy_vec) <= $past($countones(busy_vec)) + 1)); // R5

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_vtag) && $stable(disp_pidx))); // R6

    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_a
        for (genvar j = i + 1; j < NUM_PHYS; j++) begin : g_b
            AST_OWNER_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_vec[i] && busy_vec[j]) |-> (owner_flat[i*TW +: TW] != owner_flat[j*TW +: TW])); // R7
        end
    end
endmodule

bind vport_alloc vport_alloc_chk #(.NUM_PHYS(NUM_PHYS), .NUM_VIRT(NUM_VIRT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_vtag   (disp_vtag),
    .disp_pidx   (disp_pidx),
    .free_cnt    (free_cnt),
    .unbound_vec (unbound_q),
    .busy_vec    (phys_busy),
    .owner_flat  (phys_owner_flat)
);

// File: tb/vport_alloc_bench.sv
// Bench: directed scenarios for vport_alloc, one task each, self-checking.
module vport_alloc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_req_valid = 1'b0;
    logic [2:0]  dec_req_cnt = '0;
    logic        dec_grant;
    logic [15:0] dec_tags;
    logic        flush = 1'b0;
    logic        disp_valid;
    logic        disp_ready = 1'b0;
    logic [3:0]  disp_vtag;
    logic [2:0]  disp_pidx;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_pidx = '0;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    vport_alloc u_vport_alloc (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_req_valid (dec_req_valid),
        .dec_req_cnt   (dec_req_cnt),
        .dec_grant     (dec_grant),
        .dec_tags      (dec_tags),
        .flush         (flush),
        .disp_valid    (disp_valid),
        .disp_ready    (disp_ready),
        .disp_vtag     (disp_vtag),
        .disp_pidx     (disp_pidx),
        .rel_valid     (rel_valid),
        .rel_pidx      (rel_pidx)
    );

    // Compare one value and report
    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to the next cycle's drive/sample window
    task automatic nxt();
        @(posedge clk);
        #2;
    endtask

    // Let combinational outputs settle after driving
    task automatic settle();
        #1;
    endtask

    // Check a granted request returns consecutive tags starting at base
    task automatic chk_tags(input string req, input int n, input int base);
        for (int k = 0; k < n; k++) begin
            chk(req, $sformatf("tag field %0d", k), int'(dec_tags[k*4 +: 4]), base + k);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dec_req_valid = 1'b0; dec_req_cnt = '0; flush = 1'b0;
        disp_ready = 1'b0; rel_valid = 1'b0; rel_pidx = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    // R1, R2: reset state and grant rules
    task automatic t_reset_grant();
        do_reset();
        settle();
        chk("R1", "disp_valid after reset", int'(disp_valid), 0);
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        settle();
        chk("R1", "grant of 4 from full pool", int'(dec_grant), 1);
        chk_tags("R1", 4, 0);
        dec_req_cnt = 3'd0;
        settle();
        chk("R2", "grant for count 0", int'(dec_grant), 0);
        dec_req_cnt = 3'd5;
        settle();
        chk("R2", "grant for count 5", int'(dec_grant), 0);
        nxt();
        dec_req_cnt = 3'd3;
        settle();
        chk("R2", "refused request left pool intact", int'(dec_grant), 1);
        chk_tags("R2", 3, 0);
        dec_req_valid = 1'b0;
    endtask

    // R5, R6: pairing latency, dispatch order and hold
    task automatic t_dispatch_order();
        do_reset();
        dec_req_valid = 1'b1; dec_req_cnt = 3'd2;
        settle();
        chk("R2", "grant of 2", int'(dec_grant), 1);
        chk_tags("R2", 2, 0);
        nxt();
        dec_req_valid = 1'b0;
        settle();
        chk("R6", "no dispatch one cycle after grant", int'(disp_valid), 0);
        nxt();
        settle();
        chk("R5", "dispatch two cycles after grant", int'(disp_valid), 1);
        chk("R5", "first vtag", int'(disp_vtag), 0);
        chk("R5", "first pidx", int'(disp_pidx), 0);
        nxt();
        settle();
        chk("R6", "held vtag while not ready", int'(disp_vtag), 0);
        chk("R6", "held pidx while not ready", int'(disp_pidx), 0);
        disp_ready = 1'b1;
        nxt();
        settle();
        chk("R6", "second vtag", int'(disp_vtag), 1);
        chk("R5", "second pidx", int'(disp_pidx), 1);
        nxt();
        settle();
        chk("R6", "queue drained", int'(disp_valid), 0);
        disp_ready = 1'b0;
    endtask

    // R3, R4, R7, R8: oversubscription, full entries, delayed release
    task automatic t_oversub_release();
        int n;
        int errs;
        do_reset();
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        settle();
        chk_tags("R2", 4, 0);
        nxt();
        settle();
        chk_tags("R2", 4, 4);
        nxt();
        dec_req_valid = 1'b0;
        disp_ready = 1'b1;
        n = 0; errs = 0;
        for (int i = 0; i < 12; i++) begin
            settle();
            if (disp_valid) begin
                if (int'(disp_vtag) != n || int'(disp_pidx) != n) errs++;
                n++;
            end
            nxt();
        end
        chk("R7", "dispatches while filling", n, 8);
        chk("R5", "out-of-order pairings", errs, 0);
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        settle();
        chk("R3", "grant with all entries busy", int'(dec_grant), 1);
        chk_tags("R3", 4, 8);
        nxt();
        settle();
        chk("R3", "second grant with entries busy", int'(dec_grant), 1);
        chk_tags("R3", 4, 12);
        nxt();
        dec_req_cnt = 3'd1;
        settle();
        chk("R4", "grant from empty pool", int'(dec_grant), 0);
        dec_req_valid = 1'b0;
        errs = 0;
        for (int i = 0; i < 6; i++) begin
            nxt();
            settle();
            if (disp_valid) errs++;
        end
        chk("R7", "dispatches while entries full", errs, 0);
        // release entry 3 (owned by tag 3) in cycle t
        rel_valid = 1'b1; rel_pidx = 3'd3;
        nxt();
        rel_valid = 1'b0;
        dec_req_valid = 1'b1; dec_req_cnt = 3'd1;
        for (int d = 1; d <= 3; d++) begin
            settle();
            chk("R8", $sformatf("grant at t+%0d", d), int'(dec_grant), 0);
            nxt();
        end
        settle();
        chk("R8", "grant at t+4", int'(dec_grant), 1);
        chk("R8", "regained tag", int'(dec_tags[3:0]), 3);
        chk("R8", "no dispatch at t+4", int'(disp_valid), 0);
        nxt();
        dec_req_valid = 1'b0;
        settle();
        chk("R8", "dispatch at t+5", int'(disp_valid), 1);
        chk("R5", "oldest waiting tag paired", int'(disp_vtag), 8);
        chk("R7", "freed entry reused", int'(disp_pidx), 3);
        disp_ready = 1'b0;
    endtask

    // R9: flush returns unpaired tags only
    task automatic t_flush();
        do_reset();
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        nxt();
        dec_req_valid = 1'b0;
        nxt();
        flush = 1'b1; dec_req_valid = 1'b1; dec_req_cnt = 3'd1;
        settle();
        chk("R9", "grant during flush", int'(dec_grant), 0);
        chk("R9", "paired op visible in flush cycle", int'(disp_valid), 1);
        chk("R9", "paired vtag in flush cycle", int'(disp_vtag), 0);
        nxt();
        flush = 1'b0; dec_req_cnt = 3'd4;
        settle();
        chk("R9", "grant after flush", int'(dec_grant), 1);
        chk_tags("R9", 4, 1);
        nxt();
        settle();
        chk("R9", "paired op survives flush", int'(disp_valid), 1);
        chk("R9", "paired pidx survives flush", int'(disp_pidx), 0);
        chk("R10", "grant from remaining pool", int'(dec_grant), 1);
        chk_tags("R10", 4, 5);
        nxt();
        dec_req_valid = 1'b0;
    endtask

    // R10: every tag comes back after a full release cycle
    task automatic t_conserve();
        do_reset();
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        nxt();
        nxt();
        dec_req_valid = 1'b0;
        disp_ready = 1'b1;
        repeat (12) nxt();
        for (int p = 0; p < 8; p++) begin
            rel_valid = 1'b1; rel_pidx = 3'(p);
            nxt();
        end
        rel_valid = 1'b0;
        repeat (6) nxt();
        dec_req_valid = 1'b1; dec_req_cnt = 3'd4;
        for (int g = 0; g < 4; g++) begin
            settle();
            chk("R10", $sformatf("refill grant %0d", g), int'(dec_grant), 1);
            chk_tags("R10", 4, 4 * g);
            nxt();
        end
        dec_req_cnt = 3'd1;
        settle();
        chk("R10", "pool exhausted after refill", int'(dec_grant), 0);
        dec_req_valid = 1'b0;
        disp_ready = 1'b0;
    endtask

    initial begin
        t_reset_grant();
        t_dispatch_order();
        t_oversub_release();
        t_flush();
        t_conserve();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule